// File: doc/BRIEF.md
# Debug Port Reset and Interrupt Controller

This block is a serial debug port built around the standard sixteen-state test access port (TAP) controller. It is clocked by TCK and steered by TMS. A debugger shifts a 4-bit instruction in through TDI. When the instruction is updated, a system-side reset can be held or released, or an interrupt can be raised towards the CPU. The block has no streaming data path. All of its pins are plain control and status signals, so no valid/ready handshake applies.

Events from the TCK domain are carried into the system clock domain as toggles. A two-flop synchronizer and an edge detector turn each toggle back into a single event. The reset output has a minimum-hold counter, so a release command that arrives too early is deferred until the hold time has elapsed. The interrupt request is sticky. Only a CPU write of 0 clears it, and it is presented together with a fixed exception code.

Top module: `dbg_port_ctrl`

## Requirements
- R1: The TAP follows the 16-state test access port state graph. Five TCK cycles with TMS high reach Test-Logic-Reset from any state, and Test-Logic-Reset loads BYPASS (4'hF) into the instruction register. Capture-IR loads 4'b0001, which TDO shows least significant bit first during Shift-IR.
- R2: Instruction codes are shifted least significant bit first: 4'h2 is reset-assert, 4'h3 is reset-negate, 4'h5 is interrupt and 4'hF is BYPASS. Every other code selects the 1-bit bypass register, which captures 0 and delays TDI by one TCK cycle.
- R3: Updating the reset-assert code drives chip_rst high. chip_rst then stays high until a reset-negate code has been updated.
- R4: chip_rst stays high for at least MIN_HOLD+1 clk cycles after the assert event, even when reset-negate arrives earlier. A negate that arrives after the hold has elapsed releases chip_rst within a few clk cycles.
- R5: A reset-negate while chip_rst is low has no effect. A later reset-assert then holds chip_rst high with no pending release.
- R6: Updating the interrupt code sets irq_req at the third rising clk edge after the TCK edge that performs the update. irq_code reads 12'h600 while irq_req is high and 0 otherwise.
- R7: irq_req is sticky. A csr_wr with csr_wdata=0 clears it. A csr_wr with csr_wdata=1 has no effect, and neither does entering Test-Logic-Reset.
- R8: When a set event and a clearing CPU write are sampled on the same clk edge, irq_req is set.
- R9: While the interrupt code is in the instruction register, the data register is a 1-bit interrupt register. Capture-DR reads irq_req, an Update-DR of 1 sets irq_req, and an Update-DR of 0 has no effect. The interrupt code stays in the instruction register and is not replaced by BYPASS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System-domain asynchronous reset, active low |
| tck | input | 1 | Debug serial clock |
| trst_n | input | 1 | Debug-domain asynchronous reset, active low |
| tms | input | 1 | TAP mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| csr_wr | input | 1 | CPU write strobe for the interrupt flag |
| csr_wdata | input | 1 | CPU write data; 0 clears irq_req |
| irq_req | output | 1 | Sticky interrupt request |
| irq_code | output | 12 | Exception code, 12'h600 while irq_req is high |
| chip_rst | output | 1 | Chip reset, active high |

## Verification
The assertions assume the following about the inputs:
- trst_n is asserted only together with rst_n, so clearing the TCK-side toggles never looks like an event in the clk domain.
- Each TCK phase lasts at least one clk period, and updates are spaced well beyond the synchronizer latency, so no toggle is folded away.
- csr_wr and csr_wdata are synchronous to clk.

The stimulus meets these assumptions. Every TCK edge is placed on a falling clk edge and each TCK period spans three clk periods. Because of this alignment, the bench can place a CPU clear exactly on the edge that carries the set event.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_RST_ON  = 4'h2;
  localparam logic [IR_W-1:0] OP_RST_OFF = 4'h3;
  localparam logic [IR_W-1:0] OP_IRQ     = 4'h5;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
  localparam logic [11:0]     IRQ_CODE   = 12'h600;

  // event index into the toggle vector crossing domains
  localparam int EV_RST_ON  = 0;
  localparam int EV_RST_OFF = 1;
  localparam int EV_IRQ     = 2;
  localparam int EV_N       = 3;
endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_port_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      default:   nxt = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  // R1: Update-IR is only reachable through one of the exit states
  a_r1_upd_ir_entry: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_UPD_IR) |-> ($past(state) == ST_EX1_IR || $past(state) == ST_EX2_IR));
endmodule

// File: rtl/dbg_sync_chain.sv
module dbg_sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i > 0) ? i-1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_rst_hold.sv
module dbg_rst_hold #(
  parameter int MIN_HOLD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_on,
  input  logic ev_off,
  output logic rst_out
);
  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_HOLD);

  logic [CW-1:0] cnt;
  logic          pend;
  logic          done;

  assign done = (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_out <= 1'b0;
      pend    <= 1'b0;
      cnt     <= '0;
    end else if (ev_on) begin
      rst_out <= 1'b1;
      pend    <= 1'b0;
      cnt     <= '0;
    end else if (rst_out) begin
      if (!done)  cnt  <= cnt + 1'b1;
      if (ev_off) pend <= 1'b1;
      if ((pend || ev_off) && done) begin
        rst_out <= 1'b0;
        pend    <= 1'b0;
      end
    end
  end

  // R4: no release before the hold counter has saturated
  a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out && !done) |=> rst_out);
  // R5: a released output only rises on an assert event
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && !ev_on) |=> !rst_out);
endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
  import dbg_port_pkg::*;
#(
  parameter int MIN_HOLD    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  input  logic        csr_wr,
  input  logic        csr_wdata,
  output logic        irq_req,
  output logic [11:0] irq_code,
  output logic        chip_rst
);
  tap_state_e         st;
  logic [IR_W-1:0]    ir, ir_sh;
  logic               dr_sh;
  logic [EV_N-1:0]    tog, tog_s, tog_d, ev;
  logic               irq_tck;
  logic               irq_sel;

  dbg_tap_fsm u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .state(st));

  assign irq_sel = (ir == OP_IRQ);

  // ---------------- TCK domain ----------------
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_BYPASS;
      ir_sh <= '0;
      dr_sh <= 1'b0;
      tog   <= '0;
    end else begin
      unique case (st)
        ST_TLR:    ir    <= OP_BYPASS;
        ST_CAP_IR: ir_sh <= IR_CAPTURE;
        ST_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPD_IR: begin
          ir <= ir_sh;
          if (ir_sh == OP_RST_ON)  tog[EV_RST_ON]  <= ~tog[EV_RST_ON];
          if (ir_sh == OP_RST_OFF) tog[EV_RST_OFF] <= ~tog[EV_RST_OFF];
          if (ir_sh == OP_IRQ)     tog[EV_IRQ]     <= ~tog[EV_IRQ];
        end
        ST_CAP_DR: dr_sh <= irq_sel ? irq_tck : 1'b0;
        ST_SHF_DR: dr_sh <= tdi;
        ST_UPD_DR: if (irq_sel && dr_sh) tog[EV_IRQ] <= ~tog[EV_IRQ];
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)               tdo <= 1'b0;
    else if (st == ST_SHF_IR)  tdo <= ir_sh[0];
    else if (st == ST_SHF_DR)  tdo <= dr_sh;
    else                       tdo <= 1'b0;
  end

  dbg_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_irq_to_tck (
    .clk(tck), .rst_n(trst_n), .d(irq_req), .q(irq_tck));

  // ---------------- system domain ----------------
  dbg_sync_chain #(.WIDTH(EV_N), .STAGES(SYNC_STAGES)) u_ev_sync (
    .clk(clk), .rst_n(rst_n), .d(tog), .q(tog_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_d <= '0;
    else        tog_d <= tog_s;
  end

  assign ev = tog_s ^ tog_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     irq_req <= 1'b0;
    else if (ev[EV_IRQ])            irq_req <= 1'b1;
    else if (csr_wr && !csr_wdata)  irq_req <= 1'b0;
  end

  assign irq_code = irq_req ? IRQ_CODE : 12'h000;

  dbg_rst_hold #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .ev_on(ev[EV_RST_ON]), .ev_off(ev[EV_RST_OFF]),
    .rst_out(chip_rst));

  // R8: a set event always wins
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_IRQ] |=> irq_req);
  // R7: the request holds until a CPU write of zero
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !(csr_wr && !csr_wdata)) |=> irq_req);
  // R7: a clearing write without a set event drops the request
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_wdata && !ev[EV_IRQ]) |=> !irq_req);
  // R6: code tracks the request
  a_r6_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code == 12'h600));
endmodule

// File: tb/dbg_port_ctrl_bench.sv
module dbg_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 64;

  logic clk = 0, rst_n = 0, tck = 0, trst_n = 0, tms = 1, tdi = 0;
  logic csr_wr = 0, csr_wdata = 0;
  logic tdo, irq_req, chip_rst;
  logic [11:0] irq_code;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  dbg_port_ctrl #(.MIN_HOLD(HOLD)) u_dbg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .irq_req(irq_req),
    .irq_code(irq_code), .chip_rst(chip_rst));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_code(logic r);
    return r ? 12'h600 : 12'h000;
  endfunction

  function automatic logic [3:0] exp_bypass(logic [3:0] din);
    return {din[2:0], 1'b0};
  endfunction

  task automatic tck_cycle(logic m, logic d, output logic o);
    @(negedge clk); #2;
    o = tdo; tms = m; tdi = d;
    @(negedge clk); tck = 1;
    @(negedge clk); tck = 0;
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, o);
    tck_cycle(1'b0, 1'b0, o);
  endtask

  task automatic load_ir(logic [3:0] code, output logic [3:0] cap);
    logic o;
    tck_cycle(1, 0, o); tck_cycle(1, 0, o); tck_cycle(0, 0, o); tck_cycle(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      tck_cycle(i == 3, code[i], o);
      cap[i] = o;
    end
    tck_cycle(1, 0, o); tck_cycle(0, 0, o);
  endtask

  task automatic scan_dr(int n, logic [3:0] din, output logic [3:0] dout);
    logic o;
    dout = '0;
    tck_cycle(1, 0, o); tck_cycle(0, 0, o); tck_cycle(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tck_cycle(i == n-1, din[i], o);
      dout[i] = o;
    end
    tck_cycle(1, 0, o); tck_cycle(0, 0, o);
  endtask

  task automatic cpu_write(logic d);
    @(negedge clk); csr_wr = 1; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cyc(int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap, dout, din, code;
    logic exp_irq;
    int t_on;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1; trst_n = 1;
    settle(2);
    chk("R3 reset state chip_rst", chip_rst, 0);
    chk("R6 reset state irq_req", irq_req, 0);
    chk("R6 reset state irq_code", irq_code, 0);

    // R1: TLR then bypass; capture pattern
    tap_reset();
    scan_dr(4, 4'b1011, dout);
    chk("R1 TLR selects bypass", dout, exp_bypass(4'b1011));
    load_ir(4'hF, cap);
    chk("R1 IR capture 0001", cap, 4'b0001);
    // R2: unlisted code acts as bypass
    load_ir(4'h9, cap);
    scan_dr(4, 4'b0110, dout);
    chk("R2 unlisted code bypass", dout, exp_bypass(4'b0110));

    // R6 / R8: set latency and priority over a coincident clear
    load_ir(4'h5, cap);
    @(posedge clk); #1 csr_wr = 1; csr_wdata = 0;
    @(posedge clk); #1 csr_wr = 0;
    settle(4);
    chk("R8 set wins over clear", irq_req, 1);
    chk("R6 irq_code while set", irq_code, 12'h600);
    cpu_write(0); settle(2);
    chk("R7 cpu clear", irq_req, 0);
    load_ir(4'h5, cap);
    @(posedge clk); @(posedge clk); #1 csr_wr = 1; csr_wdata = 0;
    @(posedge clk); #1 csr_wr = 0;
    settle(2);
    chk("R6 set at third clk edge then cleared", irq_req, 0);

    // R7: write of 1 and TLR have no effect
    cpu_write(1); settle(3);
    chk("R7 write one while clear", irq_req, 0);
    load_ir(4'h5, cap); settle(6);
    cpu_write(1); settle(3);
    chk("R7 write one while set", irq_req, 1);
    tap_reset(); settle(3);
    chk("R7 TLR keeps request", irq_req, 1);

    // R9: scan register while interrupt code held
    load_ir(4'h5, cap);
    scan_dr(1, 4'b0000, dout);
    chk("R9 capture reads request", dout[0], 1);
    scan_dr(1, 4'b0000, dout); settle(6);
    chk("R9 command stays, no bypass", dout[0], 1);
    chk("R9 update of 0 no effect", irq_req, 1);
    cpu_write(0); settle(3);
    scan_dr(1, 4'b0001, dout); settle(6);
    chk("R9 capture reads cleared", dout[0], 0);
    chk("R9 update of 1 sets", irq_req, 1);
    cpu_write(0); settle(3);

    // R5: stray negate ignored
    load_ir(4'h3, cap); settle(6);
    chk("R5 negate without assert", chip_rst, 0);
    // R3/R4: early negate deferred
    load_ir(4'h2, cap);
    while (!chip_rst) @(negedge clk);
    t_on = cyc;
    chk("R3 assert drives reset", chip_rst, 1);
    load_ir(4'h3, cap);
    wait_cyc(t_on + HOLD - 3);
    chk("R4 held before minimum", chip_rst, 1);
    wait_cyc(t_on + HOLD + 4);
    chk("R4 released after minimum", chip_rst, 0);
    // R5: fresh assert has no stale pending release
    load_ir(4'h2, cap); settle(6);
    t_on = cyc;
    wait_cyc(t_on + HOLD + 40);
    chk("R5 no stale release", chip_rst, 1);
    load_ir(4'h3, cap); settle(6);
    chk("R4 late negate releases", chip_rst, 0);

    // random mix
    exp_irq = irq_req;
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 5)
        0: begin load_ir(4'h5, cap); exp_irq = 1; end
        1: begin din[0] = 1'($urandom); cpu_write(din[0]); if (!din[0]) exp_irq = 0; end
        2: begin
          do code = 4'($urandom); while (code == 4'h2 || code == 4'h3 || code == 4'h5);
          load_ir(code, cap);
          din = 4'($urandom);
          scan_dr(4, din, dout);
          chk("R2 random bypass", dout, exp_bypass(din));
        end
        3: begin
          load_ir(4'h5, cap); exp_irq = 1; settle(6);
          din = 4'($urandom);
          scan_dr(1, din, dout);
          chk("R9 random capture", dout[0], exp_irq);
        end
        default: tap_reset();
      endcase
      settle(6);
      chk("R7 random request", irq_req, exp_irq);
      chk("R6 random code", irq_code, exp_code(exp_irq));
    end
    chk("R3 random keeps reset low", chip_rst, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule